// File: doc/BRIEF.md
# Packed Instruction Word Slot Sequencer

This block is the fetch and issue front end of a small stack-machine core. It reads 18-bit instruction words from a local memory whose address space is split into two 512-word regions (the top address bit picks the region). Every word carries four instruction slots: three wide 5-bit slots and one narrow 3-bit slot at the bottom. The sequencer keeps the fetched word in an instruction buffer and offers its slots one at a time, as 5-bit opcodes, to a downstream execute unit under a valid/ready handshake.

Because the word stays in the buffer, a loop that fits in one word can run again and again with no memory traffic: when the execute unit accepts the micro-loop opcode while its loop counter is nonzero, issue goes back to slot 0 of the same word. A taken jump reported by the execute unit ends the word early and makes the next fetch use the jump target. Otherwise the word is done once its last slot is accepted, and the next word is fetched from the following address within the same region.

Top module: `slot_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `op_valid` is 0, `mem_rd` is 1 and `mem_addr` equals the reset address (default 10'h200, first word of the upper region).
- R2: A word requested with `mem_rd`/`mem_addr` is returned on `mem_rdata` one cycle later and taken into the buffer in that cycle; its slot 0 is offered (`op_valid`=1, `slot`=0) in the cycle after that.
- R3: Slot 0 is word bits 17:13, slot 1 is bits 12:8 and slot 2 is bits 7:3; each is presented unchanged on `op`.
- R4: Slot 3 is word bits 2:0 and is presented as the 5-bit opcode {bits 2:0, 2'b00}, so its low two opcode bits are always 0.
- R5: An issue is accepted in a cycle with `op_valid`=1 and `exe_ready`=1; when no jump or loop applies and the slot is below 3, the next cycle offers the next slot of the same word.
- R6: While `op_valid` is 1 and `exe_ready` is 0, `op` and `slot` stay unchanged and `op_valid` stays 1.
- R7: After slot 3 is accepted with no jump or loop, the next cycle requests the word following the previous one; the low 9 address bits wrap from 511 to 0 and the region bit (bit 9) is kept.
- R8: When `br_take` is 1 in an accepted issue, the rest of the word is dropped and the next cycle requests the word at `br_target`; a jump takes priority over a loop.
- R9: When the accepted opcode is the micro-loop opcode 5'b00100 (slot-3 code 3'b001) and `lp_nz` is 1, the next cycle offers slot 0 of the same buffered word with no memory read; with `lp_nz` at 0 that opcode is handled like any other.
- R10: `mem_rd` is never 1 in a cycle where `op_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 10 | Word address; bit 9 selects the region |
| mem_rdata | input | 18 | Read data, valid one cycle after the request |
| exe_ready | input | 1 | Execute unit accepts the offered opcode |
| br_take | input | 1 | Accepted opcode is a taken jump |
| br_target | input | 10 | Jump destination word address |
| lp_nz | input | 1 | Loop counter of the execute unit is nonzero |
| op_valid | output | 1 | An opcode is offered |
| op | output | 5 | Offered opcode |
| slot | output | 2 | Slot index of the offered opcode |

## Verification
Every output is registered state, so a request appears on `mem_addr` one cycle after the accepted issue that ends a word, and slot 0 appears two cycles after a request. The bench drives inputs at the falling edge, compares the outputs there against a reference that advances by exactly one clock per falling edge, and so each expected value is checked in the very cycle it is due. Stalls, loops, jumps into the last word of a region and slot-3 decoding are all covered by the same cycle-exact comparison.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_LOAD  = 2'd1,
    PH_ISSUE = 2'd2
  } seq_phase_e;

endpackage

// File: rtl/ss_slot_unpack.sv
module ss_slot_unpack #(
  parameter int WORD_W  = 18,
  parameter int OP_W    = 5,
  parameter int SHORT_W = 3,
  parameter int SLOT_N  = 4
) (
  input  logic [WORD_W-1:0]            word,
  output logic [SLOT_N-1:0][OP_W-1:0]  ops
);
  localparam int PAD_W = OP_W - SHORT_W;

  // Wide slots from the top of the word, the narrow slot at the bottom.
  for (genvar i = 0; i < SLOT_N; i++) begin : g_slot
    if (i < SLOT_N - 1) begin : g_wide
      assign ops[i] = word[WORD_W-1-i*OP_W -: OP_W];
    end else begin : g_short
      assign ops[i] = {word[SHORT_W-1:0], {PAD_W{1'b0}}};
    end
  end
endmodule

// File: rtl/ss_fetch_addr.sv
module ss_fetch_addr #(
  parameter int                REGION_AW  = 9,
  parameter logic [REGION_AW:0] RESET_ADDR = 10'h200
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_ev,
  input  logic                 jump_ev,
  input  logic [REGION_AW:0]   target,
  output logic [REGION_AW:0]   pc
);
  // Advance inside the region; the region bit is never touched.
  function automatic logic [REGION_AW:0] region_step(input logic [REGION_AW:0] a);
    return {a[REGION_AW], a[REGION_AW-1:0] + REGION_AW'(1)};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)        pc <= RESET_ADDR;
    else if (jump_ev)  pc <= target;
    else if (load_ev)  pc <= region_step(pc);
  end
endmodule

// File: rtl/ss_issue_ctl.sv
module ss_issue_ctl
  import slot_seq_pkg::*;
#(
  parameter int              WORD_W  = 18,
  parameter int              OP_W    = 5,
  parameter int              SLOT_N  = 4,
  parameter logic [OP_W-1:0] LOOP_OP = 5'b00100
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WORD_W-1:0]           mem_rdata,
  input  logic                        exe_ready,
  input  logic                        br_take,
  input  logic                        lp_nz,
  input  logic [OP_W-1:0]             cur_op,
  output logic [WORD_W-1:0]           buf_word,
  output logic [$clog2(SLOT_N)-1:0]   slot_q,
  output logic                        mem_rd,
  output logic                        op_valid,
  output logic                        load_ev,
  output logic                        jump_ev,
  output logic                        loop_ev,
  output logic                        end_ev
);
  localparam int                SLOT_W = $clog2(SLOT_N);
  localparam logic [SLOT_W-1:0] LAST   = SLOT_W'(SLOT_N - 1);

  seq_phase_e ph_q;
  logic       fire;
  logic       is_loop;

  assign fire     = (ph_q == PH_ISSUE) && exe_ready;
  assign is_loop  = (cur_op == LOOP_OP) && lp_nz;
  assign jump_ev  = fire && br_take;
  assign loop_ev  = fire && !br_take && is_loop;
  assign end_ev   = fire && !br_take && !is_loop && (slot_q == LAST);
  assign load_ev  = (ph_q == PH_LOAD);
  assign mem_rd   = (ph_q == PH_FETCH);
  assign op_valid = (ph_q == PH_ISSUE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q     <= PH_FETCH;
      slot_q   <= '0;
      buf_word <= '0;
    end else begin
      unique case (ph_q)
        PH_FETCH: ph_q <= PH_LOAD;
        PH_LOAD: begin
          buf_word <= mem_rdata;
          slot_q   <= '0;
          ph_q     <= PH_ISSUE;
        end
        PH_ISSUE: begin
          if (jump_ev || end_ev) ph_q   <= PH_FETCH;
          else if (loop_ev)      slot_q <= '0;
          else if (fire)         slot_q <= slot_q + SLOT_W'(1);
        end
        default: ph_q <= PH_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/slot_seq.sv
module slot_seq #(
  parameter int                 WORD_W     = 18,
  parameter int                 OP_W       = 5,
  parameter int                 SHORT_W    = 3,
  parameter int                 SLOT_N     = 4,
  parameter int                 REGION_AW  = 9,
  parameter logic [REGION_AW:0] RESET_ADDR = 10'h200,
  parameter logic [OP_W-1:0]    LOOP_OP    = 5'b00100
) (
  input  logic                       clk,
  input  logic                       rst_n,
  output logic                       mem_rd,
  output logic [REGION_AW:0]         mem_addr,
  input  logic [WORD_W-1:0]          mem_rdata,
  input  logic                       exe_ready,
  input  logic                       br_take,
  input  logic [REGION_AW:0]         br_target,
  input  logic                       lp_nz,
  output logic                       op_valid,
  output logic [OP_W-1:0]            op,
  output logic [$clog2(SLOT_N)-1:0]  slot
);
  logic [WORD_W-1:0]           buf_word;
  logic [SLOT_N-1:0][OP_W-1:0] ops;
  logic                        load_ev, jump_ev, loop_ev, end_ev;

  ss_slot_unpack #(
    .WORD_W(WORD_W), .OP_W(OP_W), .SHORT_W(SHORT_W), .SLOT_N(SLOT_N)
  ) u_unpack (
    .word (buf_word),
    .ops  (ops)
  );

  assign op = ops[slot];

  ss_issue_ctl #(
    .WORD_W(WORD_W), .OP_W(OP_W), .SLOT_N(SLOT_N), .LOOP_OP(LOOP_OP)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rdata (mem_rdata),
    .exe_ready (exe_ready),
    .br_take   (br_take),
    .lp_nz     (lp_nz),
    .cur_op    (op),
    .buf_word  (buf_word),
    .slot_q    (slot),
    .mem_rd    (mem_rd),
    .op_valid  (op_valid),
    .load_ev   (load_ev),
    .jump_ev   (jump_ev),
    .loop_ev   (loop_ev),
    .end_ev    (end_ev)
  );

  ss_fetch_addr #(
    .REGION_AW(REGION_AW), .RESET_ADDR(RESET_ADDR)
  ) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_ev (load_ev),
    .jump_ev (jump_ev),
    .target  (br_target),
    .pc      (mem_addr)
  );
endmodule

// File: rtl/slot_seq_chk.sv
module slot_seq_chk #(
  parameter int OP_W   = 5,
  parameter int SLOT_N = 4,
  parameter int ADDR_W = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       exe_ready,
  input logic [ADDR_W-1:0]          br_target,
  input logic                       mem_rd,
  input logic [ADDR_W-1:0]          mem_addr,
  input logic                       op_valid,
  input logic [OP_W-1:0]            op,
  input logic [$clog2(SLOT_N)-1:0]  slot,
  input logic                       jump_ev,
  input logic                       loop_ev,
  input logic                       end_ev
);
  localparam int SLOT_W = $clog2(SLOT_N);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOT_N - 1);

  logic adv_ev;
  assign adv_ev = op_valid && exe_ready && !jump_ev && !loop_ev && !end_ev;

  AST_FETCH_TO_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (!mem_rd && !op_valid) ##1 (op_valid && slot == '0)); // R2

  AST_SHORT_SLOT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && slot == LAST) |-> (op[1:0] == 2'b00)); // R4

  AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev |=> (op_valid && slot == SLOT_W'($past(slot) + SLOT_W'(1)))); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !exe_ready) |=> (op_valid && $stable(op) && $stable(slot))); // R6

  AST_WORD_END_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    end_ev |=> mem_rd); // R7

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    jump_ev |=> (mem_rd && mem_addr == $past(br_target))); // R8

  AST_LOOP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    loop_ev |=> (op_valid && slot == '0 && !mem_rd)); // R9

  AST_NO_READ_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !mem_rd); // R10
endmodule

bind slot_seq slot_seq_chk #(
  .OP_W(OP_W), .SLOT_N(SLOT_N), .ADDR_W(REGION_AW + 1)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .exe_ready (exe_ready),
  .br_target (br_target),
  .mem_rd    (mem_rd),
  .mem_addr  (mem_addr),
  .op_valid  (op_valid),
  .op        (op),
  .slot      (slot),
  .jump_ev   (jump_ev),
  .loop_ev   (loop_ev),
  .end_ev    (end_ev)
);

// File: tb/sim_slot_seq.sv
module sim_slot_seq;
  localparam int CLK_P    = 10;
  localparam int N_CYC    = 4000;
  localparam int WDOG_CYC = 200000;
  localparam logic [9:0] RST_A = 10'h200;
  localparam logic [4:0] LOOP_C = 5'b00100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_rd;
  logic [9:0]  mem_addr;
  logic [17:0] mem_rdata;
  logic        exe_ready, br_take, lp_nz;
  logic [9:0]  br_target;
  logic        op_valid;
  logic [4:0]  op;
  logic [1:0]  slot;

  logic [17:0] mem [1024];

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  slot_seq u0 (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .exe_ready(exe_ready), .br_take(br_take),
    .br_target(br_target), .lp_nz(lp_nz), .op_valid(op_valid),
    .op(op), .slot(slot)
  );

  // Memory with one-cycle read latency.
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  // Expected opcode of a slot, stated arithmetically.
  function automatic int exp_op(input logic [17:0] w, input int s);
    int v = int'(w);
    case (s)
      0:       return (v / 8192) % 32;
      1:       return (v / 256) % 32;
      2:       return (v / 8) % 32;
      default: return (v % 8) * 4;
    endcase
  endfunction

  function automatic logic [9:0] next_word(input logic [9:0] a);
    int lo = (int'(a) % 512 + 1) % 512;
    return (a >= 10'd512) ? 10'(512 + lo) : 10'(lo);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference state
  int          r_ph;      // 0 fetch, 1 load, 2 issue
  logic [9:0]  r_pc;
  logic [17:0] r_word;
  int          r_slot;
  string       r_why;     // requirement for the next fetch address / slot

  task automatic check_outputs();
    check("R2 mem_rd", int'(mem_rd), (r_ph == 0) ? 1 : 0);
    check("R10 op_valid", int'(op_valid), (r_ph == 2) ? 1 : 0);
    if (r_ph == 0) check({r_why, " mem_addr"}, int'(mem_addr), int'(r_pc));
    if (r_ph == 2) begin
      check({r_why, " slot"}, int'(slot), r_slot);
      check((r_slot == 3) ? "R4 op" : "R3 op", int'(op), exp_op(r_word, r_slot));
    end
  endtask

  initial begin
    void'($urandom(32'd9173));
    for (int i = 0; i < 1024; i++) mem[i] = 18'($urandom);
    // Directed words: loop code in slot 1 and in the narrow slot 3.
    mem[10'h200] = {5'd3, LOOP_C, 5'd17, 3'b001};
    mem[10'h201] = {5'd31, 5'd30, 5'd29, 3'b111};
    mem[10'h1FF] = {5'd1, 5'd2, LOOP_C, 3'b110};
    mem[10'h3FF] = {5'd9, 5'd8, 5'd7, 3'b001};
    mem_rdata = '0;
    rst_n = 1'b0; exe_ready = 1'b0; br_take = 1'b0; lp_nz = 1'b0; br_target = '0;
    r_ph = 0; r_pc = RST_A; r_slot = 0; r_word = '0; r_why = "R1";
    repeat (3) begin
      @(negedge clk);
      check("R1 reset op_valid", int'(op_valid), 0);
      check("R1 reset mem_rd", int'(mem_rd), 1);
      check("R1 reset mem_addr", int'(mem_addr), int'(RST_A));
    end
    rst_n = 1'b1;
    for (int c = 0; c < N_CYC; c++) begin
      int opx;
      check_outputs();
      // Stimulus: first part favours loops and stalls, later mixes jumps.
      exe_ready = ($urandom % 4) != 0;
      lp_nz     = (c < 600) ? (($urandom % 3) != 0) : (($urandom % 4) == 0);
      br_take   = (c >= 300) && (($urandom % 12) == 0);
      case ($urandom % 4)
        0: br_target = 10'h1FF;
        1: br_target = 10'h3FF;
        default: br_target = 10'($urandom);
      endcase
      // Advance reference across the coming edge.
      case (r_ph)
        0: r_ph = 1;
        1: begin
          r_word = mem[r_pc]; r_pc = next_word(r_pc);
          r_slot = 0; r_ph = 2; r_why = "R2";
        end
        default: begin
          if (exe_ready) begin
            opx = exp_op(r_word, r_slot);
            if (br_take) begin
              r_pc = br_target; r_ph = 0; r_why = "R8";
            end else if (opx == int'(LOOP_C) && lp_nz) begin
              r_slot = 0; r_why = "R9";
            end else if (r_slot == 3) begin
              r_ph = 0; r_why = "R7";
            end else begin
              r_slot++; r_why = "R5";
            end
          end else begin
            r_why = "R6";
          end
        end
      endcase
      @(negedge clk);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule